// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a per-core watchdog that escalates. Software programs a configuration word that holds a length and an escalation mode. Software then keeps the watchdog quiet by writing its poke register often enough. A prescaler divides the system clock. Its tick decrements a countdown whose upper bits come from the programmed length and whose low bits load as zero.

Each time the countdown runs out with no poke, the watchdog climbs one step of a ladder. The first step raises a first interrupt, the second raises a second interrupt, and the third requests a soft reset of the chip. The mode field sets how high the ladder may climb. A mode of zero switches the watchdog off. The running status is high whenever the mode field is nonzero.

The default parameters give a 10-bit prescaler and a 16-bit length placed above 8 zero bits. One expiry period is therefore length × 2^18 clock cycles. The bench shrinks these parameters so that the whole ladder fits in a short run.

Top module: `wdt_escalator`

## Requirements
- R1: After reset, `rd_data`, `running`, `irq_first`, `irq_second` and `rst_req` are all 0.
- R2: A write with `wr_sel`=0 stores a configuration word: mode in bits [1:0] and length in bits [LEN_W+1:2]. `rd_data` returns that word from the next cycle on, and `running` is 1 exactly when the stored mode is nonzero.
- R3: The first expiry occurs len × 2^(LOW_W+PRE_W) clock edges after the edge that takes a nonzero-mode configuration write, or after the edge that takes a poke. The outputs change on that edge. With the defaults this is len × 2^18 cycles.
- R4: In mode 3, the first expiry raises `irq_first`, the second raises `irq_second`, and the third raises `rst_req`. Each stage is timed over one full period, and the earlier outputs stay high.
- R5: In mode 1, the ladder stops after `irq_first`. Later expiries keep `irq_first` high and never raise `irq_second` or `rst_req`.
- R6: In mode 2, the ladder stops after `irq_second`. Later expiries never raise `rst_req`.
- R7: Any write with `wr_sel`=1 (poke) to a running watchdog reloads the countdown, clears the prescaler and lowers both interrupts on the next edge. The written data is ignored and `rd_data` is unchanged.
- R8: Once `rst_req` is high, pokes and further expiries leave it high. Only a configuration write or `rst_n` clears it.
- R9: Writing the configuration word 0 disables the watchdog. On the next edge all three outputs and `running` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the configuration word, 1 the poke register |
| wr_data | input | LEN_W+2 | Write data: length in the upper bits, mode in [1:0] |
| rd_data | output | LEN_W+2 | Stored configuration word |
| running | output | 1 | High while the mode is nonzero |
| irq_first | output | 1 | First-stage interrupt |
| irq_second | output | 1 | Second-stage interrupt |
| rst_req | output | 1 | Soft-reset request |

## Verification
The checker watches several properties on every cycle:
- the outputs stay ordered, so a reset request implies both interrupts and the second interrupt implies the first;
- the mode caps the ladder;
- a disabled watchdog stays quiet;
- a poke clears the interrupts;
- the reset request stays sticky;
- an expiry in the second stage of mode 3 leads to a reset request;
- prescaler ticks are spaced apart.

Only the bench scenarios can show the exact cycle on which each expiry lands after a write or a poke. They also show that poke data leaves the stored word alone, and that disabling the watchdog clears the outputs and the read-back value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_WARN  = 2'd1,
    ST_ALERT = 2'd2,
    ST_RESET = 2'd3
  } wdt_stage_e;

  // Climb one step unless the mode already caps the ladder here.
  function automatic wdt_stage_e stage_step(input wdt_stage_e cur, input logic [1:0] mode);
    if (cur >= wdt_stage_e'(mode)) return cur;
    return wdt_stage_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (!run || clear)  pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  assign tick = run && !clear && (pre_q == PRE_LAST);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             expire
);
  localparam int CNT_W = LEN_W + LOW_W;

  function automatic logic [CNT_W-1:0] reload_value(input logic [LEN_W-1:0] l);
    return {l, {LOW_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q <= CNT_W'(1));
  assign expire = run && tick && !load && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (load)       cnt_q <= reload_value(len);
    else if (tick) begin
      if (at_end)        cnt_q <= reload_value(len);
      else               cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ladder.sv
module wdt_ladder
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cfg_wr,
  input  logic       poke,
  input  logic       expire,
  output wdt_stage_e stage
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          stage <= ST_CLEAR;
    else if (cfg_wr)                     stage <= ST_CLEAR;
    else if (mode == 2'd0)               stage <= ST_CLEAR;
    else if (poke && stage != ST_RESET)  stage <= ST_CLEAR;
    else if (expire)                     stage <= stage_step(stage, mode);
  end
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  localparam int CFG_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             running,
  output logic             irq_first,
  output logic             irq_second,
  output logic             rst_req
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;

  // Named internal events used by the checker.
  logic             cfg_wr;
  logic             poke_evt;
  logic             tick;
  logic             expire;
  logic             run_nx;
  logic [LEN_W-1:0] len_nx;
  wdt_stage_e       stage;

  assign cfg_wr   = wr_en && !wr_sel;
  assign poke_evt = wr_en && wr_sel && (mode_q != 2'd0);
  assign run_nx   = cfg_wr ? (wr_data[1:0] != 2'd0) : (mode_q != 2'd0);
  assign len_nx   = cfg_wr ? wr_data[CFG_W-1:2] : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= 2'd0;
    end else if (cfg_wr) begin
      len_q  <= wr_data[CFG_W-1:2];
      mode_q <= wr_data[1:0];
    end
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode_q != 2'd0),
    .clear (cfg_wr || poke_evt),
    .tick  (tick)
  );

  wdt_countdown #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_nx),
    .load   (cfg_wr || poke_evt),
    .tick   (tick),
    .len    (len_nx),
    .expire (expire)
  );

  wdt_ladder u_ladder (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_q),
    .cfg_wr (cfg_wr),
    .poke   (poke_evt),
    .expire (expire),
    .stage  (stage)
  );

  assign rd_data    = {len_q, mode_q};
  assign running    = (mode_q != 2'd0);
  assign irq_first  = (stage != ST_CLEAR);
  assign irq_second = (stage == ST_ALERT) || (stage == ST_RESET);
  assign rst_req    = (stage == ST_RESET);
endmodule

// File: rtl/wdt_escalator_chk.sv
module wdt_escalator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_rd,
  input logic       running,
  input logic       irq_first,
  input logic       irq_second,
  input logic       rst_req,
  input logic       cfg_wr,
  input logic       poke_evt,
  input logic       tick,
  input logic       expire
);
  // R4: outputs nest
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req |-> irq_second) and (irq_second |-> irq_first));

  // R9: disabled watchdog stays quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!irq_first && !irq_second && !rst_req));

  // R5: mode 1 caps the ladder at the first interrupt
  a_r5_mode1_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'd1) |-> !irq_second);

  // R6: mode 2 never requests reset
  a_r6_mode2_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'd2) |-> !rst_req);

  // R7: poke lowers the interrupts unless reset is already requested
  a_r7_poke_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (poke_evt && !rst_req) |=> !irq_first);

  // R8: reset request is sticky
  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !cfg_wr) |=> rst_req);

  // R4: expiry in the second stage of mode 3 requests reset
  a_r4_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && irq_second && mode_rd == 2'd3) |=> rst_req);

  // R3: prescaler ticks never come back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind wdt_escalator wdt_escalator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_rd    (rd_data[1:0]),
  .running    (running),
  .irq_first  (irq_first),
  .irq_second (irq_second),
  .rst_req    (rst_req),
  .cfg_wr     (cfg_wr),
  .poke_evt   (poke_evt),
  .tick       (tick),
  .expire     (expire)
);

// File: tb/sim_wdt_escalator.sv
`timescale 1ns/1ps
module sim_wdt_escalator;
  localparam int PRE_W  = 2;
  localparam int LEN_W  = 4;
  localparam int LOW_W  = 2;
  localparam int CFG_W  = LEN_W + 2;
  localparam int UNIT   = 1 << (PRE_W + LOW_W);  // cycles per length unit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [CFG_W-1:0] wr_data = '0;
  logic [CFG_W-1:0] rd_data;
  logic running, irq_first, irq_second, rst_req;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  typedef struct {
    int         at;
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_escalator #(.PRE_W(PRE_W), .LEN_W(LEN_W), .LOW_W(LOW_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .running(running), .irq_first(irq_first),
    .irq_second(irq_second), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_at(input int at, input logic [2:0] e, input string tag);
    item_t it;
    it.at = at; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: pop scoreboard items on their cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      if (sb[0].at != cyc) check({sb[0].tag, " missed"}, cyc, sb[0].at);
      else check(sb[0].tag, {irq_first, irq_second, rst_req}, sb[0].exp);
      void'(sb.pop_front());
    end
  end

  // Drive at a negedge; returns the edge number that took the write.
  task automatic write(input logic sel, input logic [CFG_W-1:0] d, output int edge_n);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    edge_n = cyc;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic wait_edge(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  function automatic logic [CFG_W-1:0] cfg(input int len, input int mode);
    return {LEN_W'(len), 2'(mode)};
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, p, q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 running", running, 0);
    check("R1 outputs", {irq_first, irq_second, rst_req}, 0);

    // Full ladder, mode 3, len 2
    write(1'b0, cfg(2, 3), w);
    check("R2 readback", rd_data, cfg(2, 3));
    check("R2 running", running, 1);
    expect_at(w + 2*UNIT - 1, 3'b000, "R3 before first expiry");
    expect_at(w + 2*UNIT,     3'b100, "R3 R4 first expiry");
    expect_at(w + 4*UNIT - 1, 3'b100, "R4 before second");
    expect_at(w + 4*UNIT,     3'b110, "R4 second expiry");
    expect_at(w + 6*UNIT - 1, 3'b110, "R4 before third");
    expect_at(w + 6*UNIT,     3'b111, "R4 third expiry");
    expect_at(w + 8*UNIT + 3, 3'b111, "R8 sticky across expiry");
    drain();
    // R8 poke does not clear reset request
    write(1'b1, '1, p);
    check("R8 poke keeps rst_req", {irq_first, irq_second, rst_req}, 3'b111);
    // R9 disable
    write(1'b0, '0, p);
    check("R9 outputs off", {irq_first, irq_second, rst_req}, 0);
    check("R9 running off", running, 0);
    check("R9 rd_data zero", rd_data, 0);

    // R5 mode 1 cap, len 1
    write(1'b0, cfg(1, 1), w);
    expect_at(w + UNIT - 1, 3'b000, "R5 before expiry");
    expect_at(w + UNIT,     3'b100, "R5 first expiry");
    expect_at(w + 2*UNIT,   3'b100, "R5 capped second");
    expect_at(w + 3*UNIT + 1, 3'b100, "R5 capped third");
    drain();

    // R6 mode 2 cap, len 1
    write(1'b0, cfg(1, 2), w);
    check("R2 readback mode2", rd_data, cfg(1, 2));
    expect_at(w + UNIT,       3'b100, "R6 first expiry");
    expect_at(w + 2*UNIT,     3'b110, "R6 second expiry");
    expect_at(w + 3*UNIT + 1, 3'b110, "R6 no reset");
    drain();

    // R7 poke reloads, data ignored
    write(1'b0, cfg(2, 3), w);
    wait_edge(w + 19);
    write(1'b1, 6'h3d, p);
    check("R7 rd_data unchanged", rd_data, cfg(2, 3));
    expect_at(w + 2*UNIT,     3'b000, "R7 old deadline passed");
    expect_at(p + 2*UNIT - 1, 3'b000, "R7 before reloaded expiry");
    expect_at(p + 2*UNIT,     3'b100, "R7 reloaded expiry");
    drain();
    write(1'b1, 6'h00, q);
    check("R7 poke clears irq_first", {irq_first, irq_second, rst_req}, 3'b000);
    expect_at(q + 2*UNIT, 3'b100, "R7 period after poke");
    drain();

    // R8 configuration write clears reset request
    write(1'b0, cfg(1, 3), w);
    expect_at(w + 3*UNIT, 3'b111, "R8 reach reset");
    drain();
    write(1'b0, cfg(1, 3), p);
    check("R8 cfg write clears", {irq_first, irq_second, rst_req}, 3'b000);

    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule